// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM Core

This block is a cycle-accurate, synthesizable model of a synchronous burst SRAM. Its data bus never needs an idle cycle between a read and a write. A command (address, direction and byte lanes) is taken on every enabled rising edge. Read data comes out of an output register two enabled edges later. Write data uses the same bus slot: it is driven in the cycle that follows the second enabled edge and is captured at the edge after that. Because the two directions share this slot timing, reads and writes can be mixed freely at full rate.

A write therefore reaches the array three enabled edges after its command. Its address and lane selects travel through two staging registers to get there. A read that lands while an older write to the same word is still in the last stage receives that write's bytes from the bus, merged lane by lane. Otherwise it would see stale array contents.

A load/advance input either starts a new access at the given address or moves to the next word of a four-word burst. Bursts step in linear or interleaved order. The clock-enable input freezes the whole pipeline. Three chip selects gate new accesses. An asynchronous output enable and a sleep input control when the core drives the bus.

Top module: `zsram_core`

## Requirements
- R1: A read command taken at enabled edge k puts the addressed word on `dout` after enabled edge k+2. `dq_oe` is high in that slot when `oe_n` is low and `sleep` is low.
- R2: A write command taken at enabled edge k stores the `din` value captured at enabled edge k+3. Any later read of that word returns it.
- R3: `bw` is sampled with each command, and bit i selects byte lane i (`din[8i+7:8i]` for 8-bit lanes). A write changes only the selected lanes. The other lanes keep their previous contents.
- R4: Reads and writes may be issued on consecutive enabled edges in any order with no idle cycles. A read that follows a write to the same word returns the written lanes merged with the older lanes, including when the write immediately precedes it.
- R5: While `cen` is low, no register changes. `dout`, `dq_oe` (for unchanged `oe_n`/`sleep`) and all pending commands are held, and the pending write keeps sampling `din` until the next enabled edge.
- R6: A load cycle (`adv_ld`=0) performs an access only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination performs no access and later produces no drive.
- R7: With `lin_mode`=1, the n-th advance after a load at word address A uses the address with the bits above bit 1 equal to those of A and the low two bits equal to (A[1:0]+n) mod 4.
- R8: With `lin_mode`=0, the n-th advance uses low bits A[1:0] XOR (n mod 4), with the upper bits held. An advance repeats the direction of the burst's load and ignores the chip selects and `wr_en`.
- R9: `dq_oe` is low in every write data slot and whenever `oe_n` is high. Read data is valid on `dout` regardless of `oe_n`.
- R10: A high `sleep` at an enabled edge blocks that edge's access (load or advance), ends any burst, and holds `dq_oe` low while it stays high.
- R11: After reset, `dq_oe` is low and no command is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline state |
| cen | input | 1 | Clock enable; low freezes every register |
| addr | input | AW | Word address for load cycles |
| wr_en | input | 1 | 1 = write, 0 = read, on load cycles |
| bw | input | NB | Byte-lane write selects, sampled with each command |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Blocks new accesses and turns the drivers off |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | NB*BW | Write data from the bus |
| dout | output | NB*BW | Registered read data |
| dq_oe | output | 1 | Bus drive enable for `dout` |

## Verification
The assertions assume that `lin_mode` stays constant within a burst. Under that assumption, successive linear addresses differ by exactly one in the low two bits. The bench keeps the mode fixed from each load through its advances, and changes it only on load cycles. Every advance it issues follows a load, so the burst counter never wraps past four advances within one burst. The array is preloaded through ordinary writes before anything is read, so no read observes an uninitialized word.

// File: rtl/zsram_pkg.sv
package zsram_pkg;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_ADD = 1'b1
  } burst_ord_e;

  // low two address bits of the step-th word of a burst
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input burst_ord_e ord);
    logic [1:0] res;
    if (ord == ORD_ADD) res = start + step;
    else                res = start ^ step;
    return res;
  endfunction

  function automatic logic chip_selected(input logic sel0_n,
                                         input logic sel1,
                                         input logic sel2_n);
    return !sel0_n && sel1 && !sel2_n;
  endfunction

endpackage

// File: rtl/zsram_cmd_stage.sv
module zsram_cmd_stage #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen,
  input  logic          adv_ld,
  input  logic          cs0_n,
  input  logic          cs1,
  input  logic          cs2_n,
  input  logic          sleep,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] bw,
  input  logic          lin_mode,
  output logic          acc_vld,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [NB-1:0] acc_bw
);
  import zsram_pkg::*;

  localparam int HI = AW - 2;

  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  logic          burst_on_q;
  logic          burst_wr_q;

  logic          sel_now;
  logic [1:0]    step_nxt;
  logic [1:0]    off_nxt;
  logic          adv_live;

  assign sel_now  = chip_selected(cs0_n, cs1, cs2_n) && !sleep;
  assign step_nxt = step_q + 2'd1;
  assign off_nxt  = burst_offset(base_q[1:0], step_nxt, burst_ord_e'(lin_mode));
  assign adv_live = burst_on_q && !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_vld    <= 1'b0;
      acc_wr     <= 1'b0;
      acc_addr   <= '0;
      acc_bw     <= '0;
      base_q     <= '0;
      step_q     <= 2'd0;
      burst_on_q <= 1'b0;
      burst_wr_q <= 1'b0;
    end else if (cen) begin
      acc_bw <= bw;
      if (!adv_ld) begin
        acc_vld    <= sel_now;
        acc_wr     <= wr_en;
        acc_addr   <= addr;
        base_q     <= addr;
        step_q     <= 2'd0;
        burst_on_q <= sel_now;
        burst_wr_q <= wr_en;
      end else begin
        acc_vld    <= adv_live;
        acc_wr     <= burst_wr_q;
        acc_addr   <= {base_q[AW-1:2], off_nxt};
        step_q     <= step_nxt;
        burst_on_q <= adv_live;
      end
    end
  end

  // upper bits index held for readability of the burst page
  logic [HI-1:0] page_unused;
  assign page_unused = base_q[AW-1:2];

endmodule

// File: rtl/zsram_array.sv
module zsram_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wlane,
  input  logic [NB*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int ln = 0; ln < NB; ln++) begin
        if (wlane[ln]) mem[waddr][ln*BW +: BW] <= wdata[ln*BW +: BW];
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/zsram_wr_pipe.sv
module zsram_wr_pipe #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             in_vld,
  input  logic             in_wr,
  input  logic [AW-1:0]    in_addr,
  input  logic [NB-1:0]    in_bw,
  input  logic [NB*BW-1:0] din,
  input  logic [NB*BW-1:0] arr_rdata,
  output logic [AW-1:0]    arr_raddr,
  output logic             commit,
  output logic [AW-1:0]    commit_addr,
  output logic [NB-1:0]    commit_bw,
  output logic [NB*BW-1:0] dout,
  output logic             rd_vld,
  output logic             wr_slot,
  output logic [NB-1:0]    fwd_lane
);
  localparam int DW = NB * BW;

  logic          s2_vld, s2_wr;
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_bw;
  logic          s3_vld, s3_wr;
  logic [AW-1:0] s3_addr;
  logic [NB-1:0] s3_bw;
  logic [DW-1:0] merged;
  logic          fwd_hit;
  logic          s2_read;

  assign arr_raddr   = s2_addr;
  assign wr_slot     = s3_vld && s3_wr;
  assign commit      = cen && wr_slot;
  assign commit_addr = s3_addr;
  assign commit_bw   = s3_bw;
  assign fwd_hit     = wr_slot && (s3_addr == s2_addr);
  assign s2_read     = s2_vld && !s2_wr;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign fwd_lane[g]         = fwd_hit && s3_bw[g];
    assign merged[g*BW +: BW]  = fwd_lane[g] ? din[g*BW +: BW] : arr_rdata[g*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bw   <= '0;
      s3_vld  <= 1'b0;
      s3_wr   <= 1'b0;
      s3_addr <= '0;
      s3_bw   <= '0;
      rd_vld  <= 1'b0;
      dout    <= '0;
    end else if (cen) begin
      s2_vld  <= in_vld;
      s2_wr   <= in_wr;
      s2_addr <= in_addr;
      s2_bw   <= in_bw;
      s3_vld  <= s2_vld;
      s3_wr   <= s2_wr;
      s3_addr <= s2_addr;
      s3_bw   <= s2_bw;
      rd_vld  <= s2_read;
      if (s2_read) dout <= merged;
    end
  end

endmodule

// File: rtl/zsram_core.sv
module zsram_core #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [NB-1:0]    bw,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             adv_ld,
  input  logic             lin_mode,
  input  logic             sleep,
  input  logic             oe_n,
  input  logic [NB*BW-1:0] din,
  output logic [NB*BW-1:0] dout,
  output logic             dq_oe
);
  localparam int DW = NB * BW;

  logic          acc_vld, acc_wr;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] acc_bw;
  logic [AW-1:0] arr_raddr;
  logic [DW-1:0] arr_rdata;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [NB-1:0] commit_bw;
  logic          rd_vld;
  logic          wr_slot;
  logic [NB-1:0] fwd_lane;

  zsram_cmd_stage #(.AW(AW), .NB(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cen(cen), .adv_ld(adv_ld),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .sleep(sleep),
    .wr_en(wr_en), .addr(addr), .bw(bw), .lin_mode(lin_mode),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_bw(acc_bw)
  );

  zsram_wr_pipe #(.AW(AW), .NB(NB), .BW(BW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .cen(cen),
    .in_vld(acc_vld), .in_wr(acc_wr), .in_addr(acc_addr), .in_bw(acc_bw),
    .din(din), .arr_rdata(arr_rdata), .arr_raddr(arr_raddr),
    .commit(commit), .commit_addr(commit_addr), .commit_bw(commit_bw),
    .dout(dout), .rd_vld(rd_vld), .wr_slot(wr_slot), .fwd_lane(fwd_lane)
  );

  zsram_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk(clk), .we(commit), .waddr(commit_addr), .wlane(commit_bw),
    .wdata(din), .raddr(arr_raddr), .rdata(arr_rdata)
  );

  assign dq_oe = !oe_n && rd_vld && !sleep;

endmodule

// File: rtl/zsram_core_chk.sv
module zsram_core_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen,
  input logic          adv_ld,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          sleep,
  input logic          lin_mode,
  input logic          dq_oe,
  input logic          acc_vld,
  input logic [AW-1:0] acc_addr,
  input logic          wr_slot,
  input logic          rd_vld,
  input logic [DW-1:0] dout
);

  // R9
  bus_off_in_write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !wr_slot);

  // R9
  slot_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |-> !rd_vld);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> ($stable(dout) && $stable(rd_vld) && $stable(acc_vld) && $stable(acc_addr)));

  // R6
  deselect_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && !adv_ld && (cs0_n || !cs1 || cs2_n)) |=> !acc_vld);

  // R10
  sleep_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && sleep) |=> !acc_vld);

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && adv_ld && lin_mode && acc_vld && !sleep) |=>
      (acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

  // R8
  burst_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && adv_ld && acc_vld && !sleep) |=>
      (acc_vld && acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

endmodule

bind zsram_core zsram_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen(cen), .adv_ld(adv_ld),
  .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .sleep(sleep),
  .lin_mode(lin_mode), .dq_oe(dq_oe), .acc_vld(acc_vld),
  .acc_addr(acc_addr), .wr_slot(wr_slot), .rd_vld(rd_vld), .dout(dout)
);

// File: tb/zsram_core_bench.sv
`timescale 1ns/1ps
module zsram_core_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cen, wr_en, cs0_n, cs1, cs2_n, adv_ld, lin_mode, sleep, oe_n, dq_oe;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw;
  logic [DW-1:0] din, dout;

  zsram_core #(.AW(AW), .NB(NB), .BW(BW)) u_zsram_core (
    .clk(clk), .rst_n(rst_n), .cen(cen), .addr(addr), .wr_en(wr_en), .bw(bw),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .adv_ld(adv_ld), .lin_mode(lin_mode),
    .sleep(sleep), .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  typedef struct {
    bit          rd;
    bit          wr;
    bit [DW-1:0] data;
  } slot_t;

  slot_t       sb_q[$];
  bit [DW-1:0] mdl [WORDS];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench burst state
  int b_base = 0;
  int b_cnt = 0;
  bit b_on = 0;
  bit b_wr = 0;

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // csel: 0 selected, 1 cs0_n high, 2 cs1 low, 3 cs2_n high
  task automatic step(bit c, bit adv, int csel, bit wr, int a, bit [NB-1:0] lanes,
                      bit [DW-1:0] d, bit lin, bit oen, bit slp, string req);
    slot_t s;
    bit vld, opw;
    int ea, off;
    cen = c; adv_ld = adv; wr_en = wr; addr = a[AW-1:0]; bw = lanes;
    cs0_n = (csel == 1); cs1 = (csel != 2); cs2_n = (csel == 3);
    lin_mode = lin; oe_n = oen; sleep = slp;
    din = sb_q[0].wr ? sb_q[0].data : '0;
    if (c) begin
      ea = 0; vld = 0; opw = 0;
      if (!adv) begin
        vld = (csel == 0) && !slp; opw = wr; ea = a;
        b_base = a; b_cnt = 0; b_on = vld; b_wr = wr;
      end else begin
        vld = b_on && !slp; opw = b_wr; b_cnt++;
        if (lin) off = ((b_base % 4) + b_cnt) % 4;
        else     off = (b_base % 4) ^ (b_cnt % 4);
        ea = (b_base / 4) * 4 + off;
        b_on = vld;
      end
      s.rd = vld && !opw; s.wr = vld && opw; s.data = '0;
      if (s.wr) begin
        s.data = d;
        for (int ln = 0; ln < NB; ln++)
          if (lanes[ln]) mdl[ea][ln*BW +: BW] = d[ln*BW +: BW];
      end else if (s.rd) begin
        s.data = mdl[ea];
      end
      sb_q.push_back(s);
      void'(sb_q.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    s = sb_q[0];
    check(req, "dq_oe", {31'd0, dq_oe}, {31'd0, (s.rd && !oen && !slp)});
    if (s.rd) check(req, "dout", dout, s.data);
  endtask

  task automatic wr_op(int a, bit [DW-1:0] d, bit [NB-1:0] lanes, string req);
    step(1, 0, 0, 1, a, lanes, d, 1, 0, 0, req);
  endtask
  task automatic rd_op(int a, string req);
    step(1, 0, 0, 0, a, '0, '0, 1, 0, 0, req);
  endtask
  task automatic idle(string req);
    step(1, 0, 1, 0, 0, '0, '0, 1, 0, 0, req);
  endtask
  task automatic adv_op(bit lin, bit [DW-1:0] d, string req);
    step(1, 1, 0, 0, 0, '1, d, lin, 0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    slot_t z;
    z.rd = 0; z.wr = 0; z.data = '0;
    for (int i = 0; i < 3; i++) sb_q.push_back(z);
    rst_n = 0; cen = 1; adv_ld = 0; wr_en = 0; addr = '0; bw = '0;
    cs0_n = 1; cs1 = 1; cs2_n = 0; lin_mode = 1; sleep = 0; oe_n = 0; din = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R11 reset leaves drivers off
    check("R11", "dq_oe after reset", {31'd0, dq_oe}, '0);
    idle("R11");
    idle("R11");

    // R2 preload all words through ordinary writes
    for (int i = 0; i < WORDS; i++) wr_op(i, 32'hA500_0000 + i * 32'h0001_0101, '1, "R2");
    // R1 read back a range
    for (int i = 0; i < 8; i++) rd_op(i * 7 % WORDS, "R1");

    // R3 partial lane writes
    wr_op(9, 32'h1122_3344, 4'b0101, "R3");
    wr_op(10, 32'hDEAD_BEEF, 4'b1000, "R3");
    wr_op(11, 32'hCAFE_F00D, 4'b0000, "R3");
    idle("R3");
    rd_op(9, "R3"); rd_op(10, "R3"); rd_op(11, "R3");

    // R4 back-to-back mixes with immediate forwarding
    wr_op(20, 32'h0BAD_CAFE, '1, "R4");
    rd_op(20, "R4");
    wr_op(20, 32'h7700_0088, 4'b1001, "R4");
    rd_op(20, "R4");
    rd_op(20, "R4");
    wr_op(21, 32'h1357_9BDF, 4'b0110, "R4");
    wr_op(22, 32'h2468_ACE0, '1, "R4");
    rd_op(21, "R4");
    rd_op(22, "R4");

    // R5 stalls in the middle of a write/read stream
    wr_op(30, 32'h5A5A_A5A5, '1, "R5");
    rd_op(30, "R5");
    step(0, 0, 0, 1, 31, '1, 32'hFFFF_FFFF, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 31, '1, 32'hFFFF_FFFF, 1, 0, 0, "R5");
    rd_op(29, "R5");
    step(0, 0, 0, 0, 0, '0, '0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, 0, '0, '0, 1, 0, 0, "R5");
    rd_op(30, "R5");
    step(0, 0, 0, 0, 0, '0, '0, 1, 0, 0, "R5");
    idle("R5");

    // R6 each deselect pattern on a write, then read back
    step(1, 0, 1, 1, 40, '1, 32'h0101_0101, 1, 0, 0, "R6");
    step(1, 0, 2, 1, 41, '1, 32'h0202_0202, 1, 0, 0, "R6");
    step(1, 0, 3, 1, 42, '1, 32'h0303_0303, 1, 0, 0, "R6");
    step(1, 0, 2, 0, 40, '0, '0, 1, 0, 0, "R6");
    rd_op(40, "R6"); rd_op(41, "R6"); rd_op(42, "R6");

    // R7 linear write burst from offset 2, read back singly, then linear read burst
    step(1, 0, 0, 1, 50, '1, 32'h5000_0000, 1, 0, 0, "R7");
    adv_op(1, 32'h5000_0001, "R7");
    adv_op(1, 32'h5000_0002, "R7");
    adv_op(1, 32'h5000_0003, "R7");
    for (int i = 48; i < 52; i++) rd_op(i, "R7");
    step(1, 0, 0, 0, 51, '0, '0, 1, 0, 0, "R7");
    adv_op(1, '0, "R7"); adv_op(1, '0, "R7"); adv_op(1, '0, "R7");

    // R8 interleaved write burst from offset 1, interleaved read burst from offset 3
    step(1, 0, 0, 1, 57, '1, 32'h8000_0000, 0, 0, 0, "R8");
    adv_op(0, 32'h8000_0001, "R8");
    adv_op(0, 32'h8000_0002, "R8");
    adv_op(0, 32'h8000_0003, "R8");
    for (int i = 56; i < 60; i++) rd_op(i, "R8");
    step(1, 0, 0, 0, 59, '0, '0, 0, 0, 0, "R8");
    adv_op(0, '0, "R8"); adv_op(0, '0, "R8"); adv_op(0, '0, "R8");
    // R8 advance after a deselect stays idle
    idle("R8");
    adv_op(0, '0, "R8");

    // R9 oe_n high hides drive but dout still carries the data
    rd_op(12, "R9");
    step(1, 0, 0, 0, 13, '0, '0, 1, 1, 0, "R9");
    step(1, 0, 1, 0, 0, '0, '0, 1, 1, 0, "R9");
    step(1, 0, 1, 0, 0, '0, '0, 1, 1, 0, "R9");
    wr_op(14, 32'h9999_0000, '1, "R9");
    rd_op(14, "R9");

    // R10 sleep blocks load and advance, and silences reads in flight
    rd_op(15, "R10");
    step(1, 0, 0, 1, 15, '1, 32'hEEEE_EEEE, 1, 0, 1, "R10");
    step(1, 0, 0, 0, 16, '0, '0, 1, 0, 0, "R10");
    step(1, 1, 0, 0, 0, '0, '0, 1, 0, 1, "R10");
    step(1, 1, 0, 0, 0, '0, '0, 1, 0, 0, "R10");
    rd_op(15, "R10");
    for (int i = 0; i < 4; i++) idle("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule